// File: doc/BRIEF.md
# One-Wire Search Triplet Unit

This block carries out a single branch step of the device address search on a one-wire bus. A pulse on the start input makes it run two read slots through a separate slot engine. The first slot returns the address bit that all responding devices agree on. The second returns the complement of that bit. From these two bits and a preferred direction input, the block picks a branch. It then sends that branch back to the devices as one write slot.

The slot engine is driven through a one-cycle request pulse, which carries the level to drive (1 for a read slot or a write-one slot, 0 for a write-zero slot). The engine answers with a one-cycle completion pulse and the level it sampled. When the step ends, the block gives a packed 3-bit status and a one-cycle done pulse. If both read bits come back as 1, no device answered. The step then ends without a write slot, and the caller must restart the search.

Top module: `owt_triplet`

## Requirements
- R1: After reset, status_o is 3'b000, done_o is 0 and slot_req_o is 0.
- R2: A start pulse while idle is followed, one cycle later, by a slot request with slot_wbit_o = 1 (read slot). After that slot completes, a second request with slot_wbit_o = 1 follows one cycle later. The first returned level is the id bit and the second is the complement bit.
- R3: The status word packs the id bit in bit 0, the complement bit in bit 1 and the direction taken in bit 2.
- R4: When both read levels are 1, the step ends with status 3'b011 and no third slot request. done_o pulses in the cycle after the second slot completes.
- R5: When both read levels are 0, the direction is the preferred-direction value sampled with the start pulse, giving status 3'b100 for 1 and 3'b000 for 0. Later changes of pref_dir_i within the step have no effect.
- R6: When exactly one read level is 1, the direction equals the id bit, giving 3'b101 or 3'b010, whatever the preferred direction.
- R7: After a non-error decision, a third slot request follows one cycle after the second slot completes, with slot_wbit_o equal to the direction taken.
- R8: done_o is a single-cycle pulse, raised in the cycle after the final slot completes. status_o changes only together with done_o and then holds until the next step ends.
- R9: A start pulse received while a step is in progress is ignored: it causes no extra slot request and does not change the result.
- R10: A slot completion pulse received while idle is ignored: it causes no request, no done pulse and no status change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start one search step (idle only) |
| pref_dir_i | input | 1 | Preferred branch when both read bits are 0 |
| slot_req_o | output | 1 | One-cycle slot request to the slot engine |
| slot_wbit_o | output | 1 | Level for the requested slot (1 = read or write-one) |
| slot_done_i | input | 1 | One-cycle slot completion from the engine |
| slot_rbit_i | input | 1 | Level sampled by the engine, valid with slot_done_i |
| done_o | output | 1 | One-cycle step completion pulse |
| status_o | output | 3 | {direction, complement bit, id bit} |

## Verification
All eight combinations of id bit, complement bit and preferred direction are run from a vector table. This separates the error case (both 1), the free-choice case (both 0, where only the preferred direction decides) and the forced cases (one bit set, where the preferred direction must lose). Each run also counts slot requests, which tells a step that wrongly writes after an error apart from a correct one. Directed runs then flip the preferred input after start, pulse start during a step, pulse slot completion while idle, and watch the status holding after done.

// File: rtl/owt_pkg.sv
package owt_pkg;
    localparam int STAT_W   = 3;
    localparam int ID_POS   = 0;
    localparam int CMP_POS  = 1;
    localparam int DIR_POS  = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_ID  = 2'd1,
        ST_RD_CMP = 2'd2,
        ST_WR     = 2'd3
    } owt_state_e;

    typedef struct packed {
        owt_state_e          state;
        logic                id_bit;
        logic                pref;
        logic                req;
        logic                wbit;
        logic                done;
        logic [STAT_W-1:0]   pend;
        logic [STAT_W-1:0]   status;
    } owt_regs_t;
endpackage

// File: rtl/owt_decide.sv
module owt_decide
    import owt_pkg::*;
(
    input  logic              id_bit_i,
    input  logic              cmp_bit_i,
    input  logic              pref_i,
    output logic              dir_o,
    output logic              err_o,
    output logic [STAT_W-1:0] status_o
);
    always_comb begin
        err_o = id_bit_i & cmp_bit_i;
        if (!id_bit_i && !cmp_bit_i) begin
            dir_o = pref_i;
        end else begin
            dir_o = id_bit_i;
        end
        status_o          = '0;
        status_o[ID_POS]  = id_bit_i;
        status_o[CMP_POS] = cmp_bit_i;
        status_o[DIR_POS] = err_o ? 1'b0 : dir_o;
    end
endmodule

// File: rtl/owt_seq.sv
module owt_seq
    import owt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pref_dir_i,
    input  logic              slot_done_i,
    input  logic              dec_dir_i,
    input  logic              dec_err_i,
    input  logic [STAT_W-1:0] dec_status_i,
    output logic              id_bit_o,
    output logic              pref_o,
    output logic              slot_req_o,
    output logic              slot_wbit_o,
    output logic              done_o,
    output logic [STAT_W-1:0] status_o
);
    owt_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.req  = 1'b0;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_RD_ID;
                    r_d.pref  = pref_dir_i;
                    r_d.req   = 1'b1;
                    r_d.wbit  = 1'b1;
                end
            end
            ST_RD_ID: begin
                if (slot_done_i && !r_q.req) begin
                    r_d.id_bit = 1'b0;
                    r_d.state  = ST_RD_CMP;
                    r_d.req    = 1'b1;
                    r_d.wbit   = 1'b1;
                end
            end
            ST_RD_CMP: begin
                if (slot_done_i && !r_q.req) begin
                    r_d.pend = dec_status_i;
                    if (dec_err_i) begin
                        r_d.status = dec_status_i;
                        r_d.done   = 1'b1;
                        r_d.state  = ST_IDLE;
                    end else begin
                        r_d.state = ST_WR;
                        r_d.req   = 1'b1;
                        r_d.wbit  = dec_dir_i;
                    end
                end
            end
            ST_WR: begin
                if (slot_done_i && !r_q.req) begin
                    r_d.status = r_q.pend;
                    r_d.done   = 1'b1;
                    r_d.state  = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    // id bit is captured separately so it can be taken from the sampled level
    logic id_cap_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            id_cap_q <= 1'b0;
        end else begin
            r_q <= r_d;
            if (r_q.state == ST_RD_ID && slot_done_i && !r_q.req) begin
                id_cap_q <= slot_rbit_sel;
            end
        end
    end

    logic slot_rbit_sel;
    assign slot_rbit_sel = dec_status_i[CMP_POS];

    assign id_bit_o    = id_cap_q;
    assign pref_o      = r_q.pref;
    assign slot_req_o  = r_q.req;
    assign slot_wbit_o = r_q.wbit;
    assign done_o      = r_q.done;
    assign status_o    = r_q.status;
endmodule

// File: rtl/owt_triplet.sv
module owt_triplet
    import owt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pref_dir_i,
    output logic              slot_req_o,
    output logic              slot_wbit_o,
    input  logic              slot_done_i,
    input  logic              slot_rbit_i,
    output logic              done_o,
    output logic [STAT_W-1:0] status_o
);
    logic              id_bit;
    logic              pref_q;
    logic              dec_dir;
    logic              dec_err;
    logic [STAT_W-1:0] dec_status;

    // the sampled level drives the complement input; while reading the id
    // slot the sequencer picks that same level back out of the status bit
    owt_decide u_decide (
        .id_bit_i  (id_bit),
        .cmp_bit_i (slot_rbit_i),
        .pref_i    (pref_q),
        .dir_o     (dec_dir),
        .err_o     (dec_err),
        .status_o  (dec_status)
    );

    owt_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .pref_dir_i   (pref_dir_i),
        .slot_done_i  (slot_done_i),
        .dec_dir_i    (dec_dir),
        .dec_err_i    (dec_err),
        .dec_status_i (dec_status),
        .id_bit_o     (id_bit),
        .pref_o       (pref_q),
        .slot_req_o   (slot_req_o),
        .slot_wbit_o  (slot_wbit_o),
        .done_o       (done_o),
        .status_o     (status_o)
    );
endmodule

// File: rtl/owt_triplet_chk.sv
module owt_triplet_chk
    import owt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              pref_dir_i,
    input logic              slot_req_o,
    input logic              slot_wbit_o,
    input logic              slot_done_i,
    input logic              slot_rbit_i,
    input logic              done_o,
    input logic [STAT_W-1:0] status_o
);
    logic       busy_c;
    logic [1:0] nreq_c;
    logic       lastw_c;
    logic       pref_c;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_c  <= 1'b0;
            nreq_c  <= '0;
            lastw_c <= 1'b0;
            pref_c  <= 1'b0;
        end else begin
            if (start_i && !busy_c) begin
                busy_c <= 1'b1;
                nreq_c <= '0;
                pref_c <= pref_dir_i;
            end
            if (slot_req_o) begin
                nreq_c  <= nreq_c + 2'd1;
                lastw_c <= slot_wbit_o;
            end
            if (done_o) busy_c <= 1'b0;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> !done_o && !slot_req_o);

    p_reads_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req_o && nreq_c < 2'd2 |-> slot_wbit_o);

    p_slot_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((status_o[1:0] == 2'b11) ? (nreq_c == 2'd2 && !status_o[DIR_POS])
                                              : (nreq_c == 2'd3)));

    p_pref_choice_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && status_o[1:0] == 2'b00 |-> status_o[DIR_POS] == pref_c);

    p_forced_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && (status_o[ID_POS] ^ status_o[CMP_POS]) |-> status_o[DIR_POS] == status_o[ID_POS]);

    p_write_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && status_o[1:0] != 2'b11 |-> status_o[DIR_POS] == lastw_c);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_o) |-> done_o);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_c |-> !done_o);
endmodule

bind owt_triplet owt_triplet_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .pref_dir_i  (pref_dir_i),
    .slot_req_o  (slot_req_o),
    .slot_wbit_o (slot_wbit_o),
    .slot_done_i (slot_done_i),
    .slot_rbit_i (slot_rbit_i),
    .done_o      (done_o),
    .status_o    (status_o)
);

// File: tb/owt_triplet_bench.sv
module owt_triplet_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       pref_dir_i = 1'b0;
    logic       slot_done_i = 1'b0;
    logic       slot_rbit_i = 1'b0;
    logic       slot_req_o;
    logic       slot_wbit_o;
    logic       done_o;
    logic [2:0] status_o;

    int checks = 0;
    int errors = 0;
    int nreq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    owt_triplet u_owt_triplet (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pref_dir_i  (pref_dir_i),
        .slot_req_o  (slot_req_o),
        .slot_wbit_o (slot_wbit_o),
        .slot_done_i (slot_done_i),
        .slot_rbit_i (slot_rbit_i),
        .done_o      (done_o),
        .status_o    (status_o)
    );

    always @(posedge clk) if (slot_req_o) nreq <= nreq + 1;

    // [7] id  [6] comp  [5] pref  [4:2] status  [1] has write  [0] write level
    localparam logic [7:0] VEC [8] = '{
        8'b000_000_1_0, 8'b001_100_1_1, 8'b010_010_1_0, 8'b011_010_1_0,
        8'b100_101_1_1, 8'b101_101_1_1, 8'b110_011_0_0, 8'b111_011_0_0
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic respond(input int lat, input logic lvl, input logic inject);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(!slot_req_o && !done_o, "R8 quiet while slot runs", {slot_req_o, done_o}, 0);
            start_i    = inject;
            pref_dir_i = ~pref_dir_i;
        end
        @(negedge clk);
        start_i     = 1'b0;
        slot_done_i = 1'b1;
        slot_rbit_i = lvl;
        @(negedge clk);
        slot_done_i = 1'b0;
        slot_rbit_i = 1'b0;
    endtask

    task automatic run_step(input logic [7:0] v, input int lat, input logic inject);
        int base;
        @(negedge clk);
        base       = nreq;
        start_i    = 1'b1;
        pref_dir_i = v[5];
        @(negedge clk);
        start_i    = 1'b0;
        pref_dir_i = ~v[5];
        chk(slot_req_o && slot_wbit_o, "R2 first read slot", {slot_req_o, slot_wbit_o}, 3);
        respond(lat, v[7], inject);
        chk(slot_req_o && slot_wbit_o, "R2 second read slot", {slot_req_o, slot_wbit_o}, 3);
        respond(lat, v[6], inject);
        if (v[1]) begin
            chk(slot_req_o && slot_wbit_o == v[0], "R7 write slot level", {slot_req_o, slot_wbit_o}, {1'b1, v[0]});
            chk(!done_o, "R7 no done before write", done_o, 0);
            respond(lat, 1'b1, inject);
        end else begin
            chk(!slot_req_o, "R4 no write after error", slot_req_o, 0);
        end
        chk(done_o, "R8 done after final slot", done_o, 1);
        if (v[7] && v[6])      chk(status_o == v[4:2], "R4 error status", status_o, v[4:2]);
        else if (!v[7] && !v[6]) chk(status_o == v[4:2], "R5 preferred status", status_o, v[4:2]);
        else                   chk(status_o == v[4:2], "R6 forced status", status_o, v[4:2]);
        chk(status_o[0] == v[7] && status_o[1] == v[6], "R3 bit positions", status_o, v[4:2]);
        @(negedge clk);
        chk(!done_o, "R8 done single pulse", done_o, 0);
        chk(nreq - base == (v[1] ? 3 : 2), inject ? "R9 busy start ignored" : "R4 slot count",
            nreq - base, v[1] ? 3 : 2);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] held;
        repeat (3) @(negedge clk);
        chk(status_o == 3'b000 && !done_o && !slot_req_o, "R1 reset state",
            {status_o, done_o, slot_req_o}, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) run_step(VEC[k], 1 + (k % 3), 1'b0);

        // start pulses during a step, forced and free-choice cases
        run_step(VEC[1], 3, 1'b1);
        run_step(VEC[4], 2, 1'b1);
        run_step(VEC[6], 2, 1'b1);

        // status holds after done
        held = status_o;
        repeat (5) @(negedge clk);
        chk(status_o == held && !done_o, "R8 status holds", status_o, held);

        // completion while idle
        slot_done_i = 1'b1;
        slot_rbit_i = 1'b1;
        @(negedge clk);
        slot_done_i = 1'b0;
        slot_rbit_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(!slot_req_o && !done_o && status_o == held, "R10 idle completion ignored",
            {slot_req_o, done_o, status_o}, {2'b00, held});

        // a step still runs normally afterwards
        run_step(VEC[0], 1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule